// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer

This block is a memory-mapped timer with several independent 32-bit down counters (three by default). One shared start byte holds a run bit for each channel. Each channel has three registers: a reload constant, a live counter, and a 16-bit control register. The control register holds a clock-divider select, an underflow interrupt enable and a sticky underflow flag. While a channel runs, its counter steps down once per divided clock tick. When the counter passes zero it takes the reload constant back and raises its flag. This gives a periodic timer with a period set by the constant. With the constant at all-ones, the channel is a free-running down counter.

Software reaches the registers over a single-cycle synchronous port. A write uses per-byte lane enables, and a read returns data in the same cycle. Each channel drives its own level interrupt line.

Top module: `tmu_multi_timer`

## Requirements
- R1: After reset, the start byte reads 0, every constant and counter reads 0xFFFFFFFF, every control register reads 0, and all interrupt lines are low.
- R2: The register map uses byte addresses, and every access is aligned to its register's address (address bits [1:0] = 0). The start byte is at 0. Bit n of the start byte runs channel n, and bits at and above the channel count read 0. Channel n's constant is at 4+12n, its counter at 8+12n and its control register at 12+12n. Reads return the stored values. Unmapped addresses read 0.
- R3: A write changes only the byte lanes whose enable bit is set. The start byte uses lane 0. The control register uses lane 0 for bits [7:0] and lane 1 for bits [15:8].
- R4: A running channel's counter decreases by exactly 1 on each divided tick. A stopped channel's counter holds its value and produces no ticks.
- R5: Control bits [2:0] select the tick period: codes 0, 1, 2, 3 and 4 give 4, 16, 64, 256 and 1024 clock cycles. Codes 5 to 7 give 1024. The first tick falls that many cycles after the clock edge that sets the run bit.
- R6: A tick that finds the counter at 0 loads the constant on that edge and sets the flag in control bit 8. With the constant at 0xFFFFFFFF, the counter wraps from 0 to 0xFFFFFFFF.
- R7: A channel's interrupt line is high exactly while its flag (bit 8) and its enable (bit 5) are both 1.
- R8: A control write with lane 1 enabled and bit 8 = 0 clears the flag. Writing bit 8 = 1 leaves the flag as it was. If an underflow and a clearing write fall on the same edge, the flag ends up set.
- R9: Writing a different divider code restarts the channel's divider count. Clearing the run bit also resets the divider count.
- R10: Channels count, divide and flag independently of one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wen | input | 1 | Write strobe for this cycle |
| bus_addr | input | ADDR_W | Byte address |
| bus_be | input | 4 | Byte lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, in the same cycle |
| irq | output | NUM_CH | Level interrupt, one per channel |

## Verification
The bound checker checks on every cycle that a stopped channel never ticks and holds its counter, that a tick steps the counter down by one or reloads it from the constant, and that the flag sets on underflow and stays set until a clearing write. The actual divider periods, the restart on a code change, lane masking and the set-over-clear collision can only be shown by the bench scenarios. The bench compares every cycle against its behavioural model and also reads back hand-computed values at the exact edges involved.

// File: rtl/tmu_pkg.sv
package tmu_pkg;
    localparam int DATA_W      = 32;
    localparam int BE_W        = DATA_W / 8;
    localparam int CTRL_W      = 16;
    localparam int PS_W        = 3;
    localparam int PS_TOP_CODE = 4;
    localparam int DIV_W       = 2 * PS_TOP_CODE + 2;
    localparam int IE_BIT      = 5;
    localparam int FLAG_BIT    = 8;
    localparam int START_W     = 8;

    typedef struct packed {
        logic            flag;
        logic            ie;
        logic [PS_W-1:0] ps;
    } ctl_t;

    // last divider count value before a tick for a given code
    function automatic logic [DIV_W-1:0] div_last(input logic [PS_W-1:0] code);
        int unsigned e;
        e = (int'(code) > PS_TOP_CODE) ? PS_TOP_CODE : int'(code);
        return DIV_W'((4 << (2 * e)) - 1);
    endfunction

    function automatic logic [DATA_W-1:0] lane_merge(input logic [DATA_W-1:0] old_v,
                                                     input logic [DATA_W-1:0] new_v,
                                                     input logic [BE_W-1:0]   be);
        logic [DATA_W-1:0] r;
        r = old_v;
        for (int b = 0; b < BE_W; b++)
            if (be[b]) r[8*b +: 8] = new_v[8*b +: 8];
        return r;
    endfunction

    function automatic logic [CTRL_W-1:0] ctl_pack(input ctl_t c);
        logic [CTRL_W-1:0] r;
        r = '0;
        r[PS_W-1:0] = c.ps;
        r[IE_BIT]   = c.ie;
        r[FLAG_BIT] = c.flag;
        return r;
    endfunction
endpackage

// File: rtl/tmu_prescaler.sv
module tmu_prescaler
    import tmu_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            restart,
    input  logic [PS_W-1:0] code,
    output logic            tick
);
    typedef struct packed {
        logic [DIV_W-1:0] div;
    } ps_st_t;

    ps_st_t st_d, st_q;
    logic   at_last;

    always_comb begin
        st_d    = st_q;
        at_last = (st_q.div >= div_last(code));
        tick    = run && at_last;
        if (!run || restart || at_last)
            st_d.div = '0;
        else
            st_d.div = st_q.div + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tmu_channel.sv
module tmu_channel
    import tmu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              wen,
    input  logic              sel_rld,
    input  logic              sel_cnt,
    input  logic              sel_ctl,
    input  logic [BE_W-1:0]   be,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rld_o,
    output logic [DATA_W-1:0] cnt_o,
    output logic [CTRL_W-1:0] ctl_o,
    output logic              irq_o,
    output logic              tick_o,
    output logic              uflow_o
);
    typedef struct packed {
        logic [DATA_W-1:0] rld;
        logic [DATA_W-1:0] cnt;
        ctl_t              ctl;
    } ch_st_t;

    ch_st_t st_d, st_q;
    logic   tick, uflow, ps_restart, wr_ctl;

    tmu_prescaler u_ps (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (ps_restart),
        .code    (st_q.ctl.ps),
        .tick    (tick)
    );

    always_comb begin
        st_d       = st_q;
        wr_ctl     = wen && sel_ctl;
        ps_restart = wr_ctl && be[0] && (wdata[PS_W-1:0] != st_q.ctl.ps);
        uflow      = tick && (st_q.cnt == '0);

        if (tick)
            st_d.cnt = uflow ? st_q.rld : st_q.cnt - 1'b1;
        if (wen && sel_cnt)
            st_d.cnt = lane_merge(st_q.cnt, wdata, be);
        if (wen && sel_rld)
            st_d.rld = lane_merge(st_q.rld, wdata, be);

        if (wr_ctl && be[0]) begin
            st_d.ctl.ps = wdata[PS_W-1:0];
            st_d.ctl.ie = wdata[IE_BIT];
        end
        if (wr_ctl && be[1] && !wdata[FLAG_BIT])
            st_d.ctl.flag = 1'b0;
        if (uflow)
            st_d.ctl.flag = 1'b1;   // hardware set beats software clear
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.rld <= '1;
            st_q.cnt <= '1;
            st_q.ctl <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rld_o   = st_q.rld;
    assign cnt_o   = st_q.cnt;
    assign ctl_o   = ctl_pack(st_q.ctl);
    assign irq_o   = st_q.ctl.flag && st_q.ctl.ie;
    assign tick_o  = tick;
    assign uflow_o = uflow;
endmodule

// File: rtl/tmu_multi_timer.sv
module tmu_multi_timer
    import tmu_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wen,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BE_W-1:0]   bus_be,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] irq
);
    localparam int WORD_W    = ADDR_W - 2;
    localparam int REGS_PER  = 3;
    localparam int FIRST_GRP = 1;

    typedef struct packed {
        logic [NUM_CH-1:0] run;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [WORD_W-1:0] word;
    logic              aligned;
    logic              sel_start;

    logic [NUM_CH-1:0]             sel_rld, sel_cnt, sel_ctl;
    logic [NUM_CH-1:0]             tick_all, uflow_all;
    logic [NUM_CH-1:0][DATA_W-1:0] rld_all, cnt_all;
    logic [NUM_CH-1:0][CTRL_W-1:0] ctl_all;

    assign word      = bus_addr[ADDR_W-1:2];
    assign aligned   = (bus_addr[1:0] == 2'b00);
    assign sel_start = aligned && (word == '0);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam int RLD_WORD = FIRST_GRP + REGS_PER * g;

        assign sel_rld[g] = aligned && (word == WORD_W'(RLD_WORD));
        assign sel_cnt[g] = aligned && (word == WORD_W'(RLD_WORD + 1));
        assign sel_ctl[g] = aligned && (word == WORD_W'(RLD_WORD + 2));

        tmu_channel u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .run     (st_q.run[g]),
            .wen     (bus_wen),
            .sel_rld (sel_rld[g]),
            .sel_cnt (sel_cnt[g]),
            .sel_ctl (sel_ctl[g]),
            .be      (bus_be),
            .wdata   (bus_wdata),
            .rld_o   (rld_all[g]),
            .cnt_o   (cnt_all[g]),
            .ctl_o   (ctl_all[g]),
            .irq_o   (irq[g]),
            .tick_o  (tick_all[g]),
            .uflow_o (uflow_all[g])
        );
    end

    always_comb begin
        st_d = st_q;
        if (bus_wen && sel_start && bus_be[0])
            st_d.run = bus_wdata[NUM_CH-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (sel_start)
            bus_rdata[NUM_CH-1:0] = st_q.run;
        for (int i = 0; i < NUM_CH; i++) begin
            if (sel_rld[i]) bus_rdata = rld_all[i];
            if (sel_cnt[i]) bus_rdata = cnt_all[i];
            if (sel_ctl[i]) bus_rdata = DATA_W'(ctl_all[i]);
        end
    end
endmodule

// File: rtl/tmu_checker.sv
module tmu_checker
    import tmu_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          bus_wen,
    input logic [BE_W-1:0]               bus_be,
    input logic [DATA_W-1:0]             bus_wdata,
    input logic [NUM_CH-1:0]             run,
    input logic [NUM_CH-1:0]             sel_cnt,
    input logic [NUM_CH-1:0]             sel_ctl,
    input logic [NUM_CH-1:0]             tick,
    input logic [NUM_CH-1:0]             uflow,
    input logic [NUM_CH-1:0][DATA_W-1:0] rld,
    input logic [NUM_CH-1:0][DATA_W-1:0] cnt,
    input logic [NUM_CH-1:0][CTRL_W-1:0] ctl
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        logic wr_cnt, clr_req;
        assign wr_cnt  = bus_wen && sel_cnt[g];
        assign clr_req = bus_wen && sel_ctl[g] && bus_be[1] && !bus_wdata[FLAG_BIT];

        assert_no_tick_stopped_R4: assert property (@(posedge clk) disable iff (!rst_n)
            !run[g] |-> !tick[g]);

        assert_hold_stopped_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!run[g] && !wr_cnt) |=> $stable(cnt[g]));

        assert_step_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (tick[g] && cnt[g] != '0 && !wr_cnt) |=> (cnt[g] == $past(cnt[g]) - 1'b1));

        assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (uflow[g] && !wr_cnt) |=> (cnt[g] == $past(rld[g])));

        assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
            uflow[g] |=> ctl[g][FLAG_BIT]);

        assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (ctl[g][FLAG_BIT] && !clr_req) |=> ctl[g][FLAG_BIT]);
    end
endmodule

bind tmu_multi_timer tmu_checker #(.NUM_CH(NUM_CH)) u_tmu_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wen   (bus_wen),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .run       (st_q.run),
    .sel_cnt   (sel_cnt),
    .sel_ctl   (sel_ctl),
    .tick      (tick_all),
    .uflow     (uflow_all),
    .rld       (rld_all),
    .cnt       (cnt_all),
    .ctl       (ctl_all)
);

// File: tb/tmu_multi_timer_test.sv
module tmu_multi_timer_test;
    localparam int NCH = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        b_wen = 1'b0;
    logic [5:0]  b_addr = '0;
    logic [3:0]  b_be = '0;
    logic [31:0] b_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NCH-1:0] irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;
    string cur_req = "R1";

    // behavioural reference state
    bit          m_run   [NCH];
    logic [31:0] m_rld   [NCH];
    logic [31:0] m_cnt   [NCH];
    int          m_code  [NCH];
    bit          m_ie    [NCH];
    bit          m_flag  [NCH];
    int          m_phase [NCH];

    always #4 clk = ~clk;

    tmu_multi_timer uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wen   (b_wen),
        .bus_addr  (b_addr),
        .bus_be    (b_be),
        .bus_wdata (b_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    function automatic logic [31:0] merge(logic [31:0] o, logic [31:0] n, logic [3:0] be);
        logic [31:0] r = o;
        for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = n[8*b +: 8];
        return r;
    endfunction

    function automatic int period(int code);
        int c = (code > 4) ? 4 : code;
        return 4 << (2 * c);
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NCH; i++) begin
            m_run[i] = 0; m_rld[i] = '1; m_cnt[i] = '1;
            m_code[i] = 0; m_ie[i] = 0; m_flag[i] = 0; m_phase[i] = 0;
        end
    endtask

    task automatic model_edge();
        bit wr_start = b_wen && b_addr == 6'd0 && b_be[0];
        for (int i = 0; i < NCH; i++) begin
            bit tk, uf, wc;
            tk = m_run[i] && (m_phase[i] + 1 == period(m_code[i]));
            uf = tk && (m_cnt[i] == 0);
            wc = b_wen && (b_addr == 6'(12 + 12 * i));
            m_phase[i] = (!m_run[i] || tk) ? 0 : m_phase[i] + 1;
            if (tk) m_cnt[i] = uf ? m_rld[i] : m_cnt[i] - 1;
            if (b_wen && b_addr == 6'(8 + 12 * i)) m_cnt[i] = merge(m_cnt[i], b_wdata, b_be);
            if (b_wen && b_addr == 6'(4 + 12 * i)) m_rld[i] = merge(m_rld[i], b_wdata, b_be);
            if (wc && b_be[0]) begin
                if (int'(b_wdata[2:0]) != m_code[i]) m_phase[i] = 0;
                m_code[i] = int'(b_wdata[2:0]);
                m_ie[i]   = b_wdata[5];
            end
            if (wc && b_be[1] && !b_wdata[8]) m_flag[i] = 0;
            if (uf) m_flag[i] = 1;
        end
        if (wr_start)
            for (int i = 0; i < NCH; i++) m_run[i] = b_wdata[i];
    endtask

    function automatic logic [31:0] model_read(logic [5:0] a);
        logic [31:0] r = '0;
        if (a == 0) for (int i = 0; i < NCH; i++) r[i] = m_run[i];
        for (int i = 0; i < NCH; i++) begin
            if (a == 6'(4 + 12 * i)) r = m_rld[i];
            if (a == 6'(8 + 12 * i)) r = m_cnt[i];
            if (a == 6'(12 + 12 * i)) r = {23'd0, m_flag[i], 2'd0, m_ie[i], 2'd0, 3'(m_code[i])};
        end
        return r;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare();
        logic [NCH-1:0] mi;
        for (int i = 0; i < NCH; i++) mi[i] = m_flag[i] && m_ie[i];
        check(cur_req, 32'(irq), 32'(mi));
        check(cur_req, bus_rdata, model_read(b_addr));
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) step();
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d, logic [3:0] be);
        b_wen = 1; b_addr = a; b_wdata = d; b_be = be;
        step();
        b_wen = 0; b_be = '0;
    endtask

    task automatic rd_check(string req, logic [5:0] a, logic [31:0] exp);
        b_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : stim
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R1 reset state
        cur_req = "R1";
        rd_check("R1", 6'd0, 32'h0);
        rd_check("R1", 6'd4, 32'hFFFF_FFFF);
        rd_check("R1", 6'd20, 32'hFFFF_FFFF);
        rd_check("R1", 6'd36, 32'h0);
        check("R1", 32'(irq), 32'h0);

        // R2 register map readback
        cur_req = "R2";
        wr(6'd16, 32'h1234_5678, 4'hF);
        rd_check("R2", 6'd16, 32'h1234_5678);
        wr(6'd36, 32'h0000_0123, 4'h3);
        rd_check("R8", 6'd36, 32'h0000_0023);
        wr(6'd0, 32'hFF, 4'h1);
        rd_check("R2", 6'd0, 32'h7);
        wr(6'd0, 32'h0, 4'h1);
        rd_check("R2", 6'd40, 32'h0);

        // R3 lane masking
        cur_req = "R3";
        wr(6'd8, 32'hAABB_CCDD, 4'b0010);
        rd_check("R3", 6'd8, 32'hFFFF_CCFF);

        // R4/R6/R7 periodic operation on channel 0
        cur_req = "R6";
        wr(6'd4, 32'd5, 4'hF);
        wr(6'd8, 32'd3, 4'hF);
        wr(6'd12, 32'h0020, 4'h3);
        wr(6'd0, 32'h1, 4'h1);
        idle(15);
        rd_check("R4", 6'd8, 32'd0);
        check("R7", 32'(irq[0]), 32'd0);
        step();
        rd_check("R6", 6'd8, 32'd5);
        rd_check("R6", 6'd12, 32'h0120);
        check("R7", 32'(irq[0]), 32'd1);

        // R8 software clear
        cur_req = "R8";
        wr(6'd12, 32'h0020, 4'h3);
        check("R8", 32'(irq[0]), 32'd0);
        rd_check("R8", 6'd12, 32'h0020);

        // R4 stopped channel holds
        cur_req = "R4";
        wr(6'd0, 32'h0, 4'h1);
        idle(10);
        rd_check("R4", 6'd8, 32'd5);

        // R8 set beats clear on the same edge
        cur_req = "R8";
        wr(6'd8, 32'd0, 4'hF);
        wr(6'd0, 32'h1, 4'h1);
        idle(3);
        wr(6'd12, 32'h0020, 4'h3);
        rd_check("R8", 6'd12, 32'h0120);
        rd_check("R8", 6'd8, 32'd5);
        wr(6'd0, 32'h0, 4'h1);

        // R7 enable gating
        cur_req = "R7";
        wr(6'd12, 32'h0000, 4'h1);
        check("R7", 32'(irq[0]), 32'd0);
        rd_check("R7", 6'd12, 32'h0100);
        wr(6'd12, 32'h0020, 4'h1);
        check("R7", 32'(irq[0]), 32'd1);
        wr(6'd12, 32'h0000, 4'h3);

        // R5/R10 divider periods on channels 1 and 2
        cur_req = "R5";
        wr(6'd20, 32'd2, 4'hF);
        wr(6'd24, 32'h0001, 4'h3);
        wr(6'd28, 32'h10, 4'hF);
        wr(6'd32, 32'd1, 4'hF);
        wr(6'd36, 32'h0026, 4'h3);
        wr(6'd0, 32'h6, 4'h1);
        idle(47);
        rd_check("R5", 6'd20, 32'd0);
        step();
        rd_check("R5", 6'd20, 32'h1234_5678);
        check("R10", 32'(irq), 32'd0);
        rd_check("R10", 6'd8, 32'd5);
        idle(1999);
        rd_check("R5", 6'd32, 32'd0);
        check("R5", 32'(irq[2]), 32'd0);
        step();
        rd_check("R5", 6'd32, 32'h10);
        check("R5", 32'(irq[2]), 32'd1);
        wr(6'd0, 32'h0, 4'h1);
        wr(6'd24, 32'h0001, 4'h2);
        wr(6'd36, 32'h0026, 4'h2);
        check("R8", 32'(irq), 32'd0);

        // R9 divider restart on code change
        cur_req = "R9";
        wr(6'd8, 32'd10, 4'hF);
        wr(6'd12, 32'h0001, 4'h1);
        wr(6'd0, 32'h1, 4'h1);
        idle(9);
        wr(6'd12, 32'h0000, 4'h1);
        idle(3);
        rd_check("R9", 6'd8, 32'd10);
        step();
        rd_check("R9", 6'd8, 32'd9);
        wr(6'd0, 32'h0, 4'h1);

        // R6 free-running wrap
        cur_req = "R6";
        wr(6'd4, 32'hFFFF_FFFF, 4'hF);
        wr(6'd8, 32'd0, 4'hF);
        wr(6'd0, 32'h1, 4'h1);
        idle(4);
        rd_check("R6", 6'd8, 32'hFFFF_FFFF);
        idle(4);
        rd_check("R6", 6'd8, 32'hFFFF_FFFE);
        wr(6'd0, 32'h0, 4'h1);
        idle(4);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule